// File: doc/BRIEF.md
# Banked memory address decoder

This block is the address glue for an 8-bit processor with a 64KB address space. It looks at the top eight address lines (A15..A8) and drives active-low chip selects for the RAM, the boot ROM, a dual UART, an IDE port and eight expansion slots. From the processor read/write line and the two bus clock phases it also makes separate active-low read and write strobes.

The CPU address space is split into four 16KB quarters:

- 0x0000-0x3FFF is RAM. It always lands in SRAM bank 0.
- 0x4000-0x7FFF is RAM, mapped through a 5-bit bank register. That register drives the upper SRAM address lines, so this window can reach any of 32 banks of 16KB.
- 0x8000-0xBFFF is an I/O page, cut into 256-byte slots.
- 0xC000-0xFFFF is ROM.

Two protect inputs can withhold the write strobe from ROM. One covers the whole ROM. The other covers only the boot-code region at the top of the ROM.

The bank register is loaded by a CPU write to its own I/O slot. It takes the new value when E falls, as seen on the system clock. The CPU can read the register back through the data output.

Top module: `bank_decoder`

## Requirements
- R1: After reset the bank register holds 0. With address 0x40xx, sram_hi is then 0 and a read of the bank slot returns 0.
- R2: cs_ram_n is low for A15..A8 in 0x00-0x7F. For 0x00-0x3F, sram_hi is 0 whatever the bank register holds.
- R3: For A15..A8 in 0x40-0x7F, sram_hi equals the bank register.
- R4: cs_rom_n is low for A15..A8 in 0xC0-0xFF.
- R5: In the I/O page the slots are decoded as follows:
  - 0x80 selects the UART (cs_uart_n).
  - 0x81 selects the IDE port (cs_ide_n).
  - 0x88+k selects expansion slot k (cs_exp_n[k], k = 0..7).
  - 0x82 is the bank register and drives no chip select.
  - Every other I/O slot (0x83-0x87, 0x90-0xBF) selects nothing.
- R6: At most one chip select is low for any address, and none is low for an unassigned slot.
- R7: rd_n is low exactly when rw=1 and E or Q is high.
- R8: wr_n is low exactly when rw=0, E is high and the access is not write-protected.
- R9: The protect inputs act only on ROM writes:
  - wp_rom=1 blocks the write strobe for the whole ROM (0xC0-0xFF).
  - wp_boot=1 blocks it only for 0xF0-0xFF.
  - Writes to RAM and I/O are not affected by either input.
- R10: The bank register takes data_in at the clock edge where E is first sampled low after being high, provided the address is 0x82 and rw=0 at that edge. An E fall at any other address, or with rw=1, leaves it unchanged.
- R11: data_oe is high exactly when the address is 0x82 and rd_n is low. data_out is then {3'b000, bank}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples E |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hi | input | 8 | CPU address lines A15..A8 |
| rw | input | 1 | CPU read/write, 1 = read |
| clk_e | input | 1 | Bus clock phase E |
| clk_q | input | 1 | Bus clock phase Q |
| wp_rom | input | 1 | Write-protect the whole ROM |
| wp_boot | input | 1 | Write-protect the boot region 0xF000-0xFFFF |
| data_in | input | 5 | Low data lines, the value to load into the bank register |
| data_out | output | 8 | Bank register read-back value |
| data_oe | output | 1 | Drive data_out onto the CPU bus |
| cs_ram_n | output | 1 | RAM select, active low |
| cs_rom_n | output | 1 | ROM select, active low |
| cs_uart_n | output | 1 | UART select, active low |
| cs_ide_n | output | 1 | IDE port select, active low |
| cs_exp_n | output | 8 | Expansion slot selects, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| sram_hi | output | 5 | SRAM address lines SA18..SA14 |

## Verification
The hardest thing to reach from the ports is a bank load. It needs the address held at slot 0x82 with rw low across a high-to-low transition of E, and that transition is seen only through the sampling clock. The stimulus raises E for one clock and then drops it with address, rw and data held steady.

The bench checks each new bank value through both the banked window and the read-back path. It also checks that the fixed window ignores the bank value.

Near-miss cases are driven in the same way:
- an E fall at slot 0x83;
- an E fall at 0x82 with rw high.

Both must leave the register untouched.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
    localparam int AHI_W  = 8;
    localparam int BANK_W = 5;
    localparam int N_EXP  = 8;
    localparam int DATA_W = 8;

    localparam logic [AHI_W-1:0] SLOT_UART = 8'h80;
    localparam logic [AHI_W-1:0] SLOT_IDE  = 8'h81;
    localparam logic [AHI_W-1:0] SLOT_BANK = 8'h82;
    localparam logic [AHI_W-1:0] SLOT_EXP0 = 8'h88;
    localparam logic [AHI_W-1:0] BOOT_BASE = 8'hF0;

    typedef struct packed {
        logic             ram;
        logic             rom;
        logic             uart;
        logic             ide;
        logic [N_EXP-1:0] exp;
        logic             bank;
        logic             boot;
    } sel_t;
endpackage

// File: rtl/bdec_map.sv
module bdec_map
    import bdec_pkg::*;
(
    input  logic [AHI_W-1:0] addr_hi,
    output sel_t             sel
);
    logic             io_page;
    logic [N_EXP-1:0] exp_hit;

    assign io_page = (addr_hi[AHI_W-1 -: 2] == 2'b10);

    for (genvar k = 0; k < N_EXP; k++) begin : g_exp
        assign exp_hit[k] = io_page && (addr_hi == SLOT_EXP0 + AHI_W'(k));
    end

    always_comb begin
        sel      = '0;
        sel.ram  = (addr_hi[AHI_W-1] == 1'b0);
        sel.rom  = (addr_hi[AHI_W-1 -: 2] == 2'b11);
        sel.uart = io_page && (addr_hi == SLOT_UART);
        sel.ide  = io_page && (addr_hi == SLOT_IDE);
        sel.bank = io_page && (addr_hi == SLOT_BANK);
        sel.exp  = exp_hit;
        sel.boot = sel.rom && (addr_hi >= BOOT_BASE);
    end
endmodule

// File: rtl/bdec_strobe.sv
module bdec_strobe (
    input  logic rw,
    input  logic clk_e,
    input  logic clk_q,
    input  logic rom_hit,
    input  logic boot_hit,
    input  logic wp_rom,
    input  logic wp_boot,
    output logic rd_n,
    output logic wr_n
);
    logic blocked;

    always_comb begin
        blocked = rom_hit && (wp_rom || (wp_boot && boot_hit));
        rd_n    = !(rw && (clk_e || clk_q));
        wr_n    = !(!rw && clk_e && !blocked);
    end
endmodule

// File: rtl/bdec_bank.sv
module bdec_bank
    import bdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_e,
    input  logic              rw,
    input  logic              bank_hit,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] bank
);
    typedef struct packed {
        logic              e;
        logic [BANK_W-1:0] bank;
    } st_t;

    st_t st_d, st_q;
    logic load;

    always_comb begin
        st_d   = st_q;
        st_d.e = clk_e;
        load   = st_q.e && !clk_e && !rw && bank_hit;
        if (load) st_d.bank = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank = st_q.bank;

    // R10
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.e && !clk_e && !rw && bank_hit) |=> $stable(bank));

    // R10
    bank_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.e && !clk_e && !rw && bank_hit) |=> (bank == $past(din)));
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
    import bdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AHI_W-1:0]  addr_hi,
    input  logic              rw,
    input  logic              clk_e,
    input  logic              clk_q,
    input  logic              wp_rom,
    input  logic              wp_boot,
    input  logic [BANK_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              cs_ram_n,
    output logic              cs_rom_n,
    output logic              cs_uart_n,
    output logic              cs_ide_n,
    output logic [N_EXP-1:0]  cs_exp_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [BANK_W-1:0] sram_hi
);
    sel_t              sel;
    logic [BANK_W-1:0] bank;

    bdec_map u_map (
        .addr_hi (addr_hi),
        .sel     (sel)
    );

    bdec_strobe u_strobe (
        .rw       (rw),
        .clk_e    (clk_e),
        .clk_q    (clk_q),
        .rom_hit  (sel.rom),
        .boot_hit (sel.boot),
        .wp_rom   (wp_rom),
        .wp_boot  (wp_boot),
        .rd_n     (rd_n),
        .wr_n     (wr_n)
    );

    bdec_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_e    (clk_e),
        .rw       (rw),
        .bank_hit (sel.bank),
        .din      (data_in),
        .bank     (bank)
    );

    always_comb begin
        cs_ram_n  = !sel.ram;
        cs_rom_n  = !sel.rom;
        cs_uart_n = !sel.uart;
        cs_ide_n  = !sel.ide;
        cs_exp_n  = ~sel.exp;
        data_oe   = sel.bank && !rd_n;
        data_out  = {{(DATA_W-BANK_W){1'b0}}, bank};
        sram_hi   = (addr_hi[AHI_W-1 -: 2] == 2'b00) ? '0 : bank;
    end

    // R6
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~cs_ram_n, ~cs_rom_n, ~cs_uart_n, ~cs_ide_n, ~cs_exp_n}));

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R8
    wr_needs_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (clk_e && !rw));

    // R9
    rom_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_rom_n && wp_rom) |-> wr_n);

    // R11
    oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (rw && cs_ram_n && cs_rom_n));
endmodule

// File: tb/bank_decoder_tb.sv
module bank_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr_hi = 8'h00;
    logic       rw = 1'b1, clk_e = 1'b0, clk_q = 1'b0, wp_rom = 1'b0, wp_boot = 1'b0;
    logic [4:0] data_in = 5'h00;
    logic [7:0] data_out;
    logic       data_oe, cs_ram_n, cs_rom_n, cs_uart_n, cs_ide_n, rd_n, wr_n;
    logic [7:0] cs_exp_n;
    logic [4:0] sram_hi;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bank_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .rw(rw), .clk_e(clk_e),
        .clk_q(clk_q), .wp_rom(wp_rom), .wp_boot(wp_boot), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .cs_ram_n(cs_ram_n),
        .cs_rom_n(cs_rom_n), .cs_uart_n(cs_uart_n), .cs_ide_n(cs_ide_n),
        .cs_exp_n(cs_exp_n), .rd_n(rd_n), .wr_n(wr_n), .sram_hi(sram_hi)
    );

    // {addr, rw e q wp_rom wp_boot, sel(ram rom uart ide exp7..0), rd_n wr_n}
    localparam int NV = 18;
    localparam logic [26:0] VEC [NV] = '{
        {8'h00, 5'b11000, 12'h800, 2'b01},
        {8'h3F, 5'b01000, 12'h800, 2'b10},
        {8'h40, 5'b10100, 12'h800, 2'b01},
        {8'h7F, 5'b00100, 12'h800, 2'b11},
        {8'h80, 5'b11000, 12'h200, 2'b01},
        {8'h81, 5'b01000, 12'h100, 2'b10},
        {8'h82, 5'b10000, 12'h000, 2'b11},
        {8'h85, 5'b01000, 12'h000, 2'b10},
        {8'h88, 5'b11000, 12'h001, 2'b01},
        {8'h8F, 5'b11000, 12'h080, 2'b01},
        {8'h90, 5'b11000, 12'h000, 2'b01},
        {8'hBF, 5'b01000, 12'h000, 2'b10},
        {8'hC0, 5'b01010, 12'h400, 2'b11},
        {8'hC0, 5'b01001, 12'h400, 2'b10},
        {8'hF0, 5'b01001, 12'h400, 2'b11},
        {8'hEF, 5'b01001, 12'h400, 2'b10},
        {8'hFF, 5'b11010, 12'h400, 2'b01},
        {8'h20, 5'b01011, 12'h800, 2'b10}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Hold address/rw/data across one E high-to-low transition.
    task automatic e_cycle(input logic [7:0] a, input logic r, input logic [4:0] d);
        @(negedge clk);
        addr_hi = a; rw = r; data_in = d; clk_e = 1'b1;
        @(negedge clk);
        clk_e = 1'b0;
        @(negedge clk);
        rw = 1'b1;
    endtask

    task automatic read_bank(input string tag, input logic [4:0] exp);
        @(negedge clk);
        addr_hi = 8'h82; rw = 1'b1; clk_e = 1'b1;
        #1;
        check(tag, {31'd0, data_oe}, 32'd1);
        check(tag, {24'd0, data_out}, {27'd0, exp});
        @(negedge clk);
        clk_e = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        addr_hi = 8'h40;
        #1;
        check("R1 sram_hi", {27'd0, sram_hi}, 32'd0);
        check("R1 oe idle", {31'd0, data_oe}, 32'd0);
        read_bank("R1 readback", 5'd0);

        // R2 R4 R5 R6 R7 R8 R9 vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            addr_hi = VEC[i][26:19];
            rw      = VEC[i][18];
            clk_e   = VEC[i][17];
            clk_q   = VEC[i][16];
            wp_rom  = VEC[i][15];
            wp_boot = VEC[i][14];
            #1;
            check($sformatf("R2 R4 R5 R6 sel vec%0d", i),
                  {20'd0, ~cs_ram_n, ~cs_rom_n, ~cs_uart_n, ~cs_ide_n, ~cs_exp_n},
                  {20'd0, VEC[i][13:2]});
            check($sformatf("R7 R8 R9 strobe vec%0d", i),
                  {30'd0, rd_n, wr_n}, {30'd0, VEC[i][1:0]});
        end
        @(negedge clk);
        clk_e = 1'b0; clk_q = 1'b0; wp_rom = 1'b0; wp_boot = 1'b0; rw = 1'b1;

        // R10 R3 load and map
        e_cycle(8'h82, 1'b0, 5'h1F);
        addr_hi = 8'h40; #1;
        check("R3 banked 0x40", {27'd0, sram_hi}, 32'h1F);
        addr_hi = 8'h7F; #1;
        check("R3 banked 0x7F", {27'd0, sram_hi}, 32'h1F);
        addr_hi = 8'h10; #1;
        check("R2 fixed window", {27'd0, sram_hi}, 32'd0);
        read_bank("R11 readback 1F", 5'h1F);

        e_cycle(8'h82, 1'b0, 5'h05);
        addr_hi = 8'h55; #1;
        check("R10 reload", {27'd0, sram_hi}, 32'h05);

        // R10 ignored: wrong slot, then read cycle at the slot
        e_cycle(8'h83, 1'b0, 5'h0A);
        addr_hi = 8'h40; #1;
        check("R10 other slot", {27'd0, sram_hi}, 32'h05);
        e_cycle(8'h82, 1'b1, 5'h0A);
        addr_hi = 8'h40; #1;
        check("R10 read cycle", {27'd0, sram_hi}, 32'h05);

        // R11 read via Q only, and no drive on a write
        @(negedge clk);
        addr_hi = 8'h82; rw = 1'b1; clk_e = 1'b0; clk_q = 1'b1; #1;
        check("R11 oe on Q", {31'd0, data_oe}, 32'd1);
        check("R11 data on Q", {24'd0, data_out}, 32'h05);
        @(negedge clk);
        clk_q = 1'b0; rw = 1'b0; clk_e = 1'b1; #1;
        check("R11 no oe on write", {31'd0, data_oe}, 32'd0);
        @(negedge clk);
        rw = 1'b1; clk_e = 1'b0; addr_hi = 8'h81; #1;
        check("R11 no oe other slot", {31'd0, data_oe}, 32'd0);

        // R1 reset clears the bank
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        addr_hi = 8'h40; #1;
        check("R1 reset clears", {27'd0, sram_hi}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule